// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in and returns the 16-bit sum and the carry-out. It never waits for a carry to ripple through sixteen bit positions. Each bit position first forms a local generate term (both operand bits set) and a local propagate term (exactly one operand bit set). The bits are then split into four 4-bit groups. In each group, a lookahead unit works out every internal carry straight from those terms and the group's own carry-in. The same unit also condenses the group into one group generate bit and one group propagate bit.

A second lookahead unit, built exactly like the first, takes the four group pairs and the adder's carry-in. It produces the carry into each group, together with a generate bit and a propagate bit for the whole 16-bit word. Those two word-level bits are outputs of the block. A third lookahead level can therefore join four copies into a 64-bit adder. The block holds no state: its outputs follow its inputs through logic alone.

Top module: `cla_adder16`

## Requirements
- R1: `sumOut` equals (`opA` + `opB` + `carryIn`) modulo 2^16, for every input combination.
- R2: `carryOut` is bit 16 of the 17-bit result `opA` + `opB` + `carryIn`.
- R3: `wordGen` is 1 exactly when `opA` + `opB` is 2^16 or more. The value of `carryIn` has no effect on it.
- R4: `wordProp` is 1 exactly when every one of the 16 bit positions has exactly one of its two operand bits set (`opA` XOR `opB` is all ones). The value of `carryIn` has no effect on it.
- R5: `carryOut` equals `wordGen` OR (`wordProp` AND `carryIn`).
- R6: A carry-in can travel through all 16 positions. With `opA` = 16'hFFFF, `opB` = 0 and `carryIn` = 1, the result is `sumOut` = 0 and `carryOut` = 1.
- R7: A carry leaving one 4-bit group reaches the next group. For example, 16'h000F + 16'h0001 gives 16'h0010, 16'h00FF + 16'h0001 gives 16'h0100, and 16'h0FFF + 16'h0001 gives 16'h1000.
- R8: With both operands zero and `carryIn` = 0, all four outputs are 0.
- R9: The block is purely combinational. New inputs show up on the outputs within the same clock period, and no clock or reset is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First addend |
| opB | input | 16 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |
| wordGen | output | 1 | Word-level generate, for a further lookahead level |
| wordProp | output | 1 | Word-level propagate, for a further lookahead level |

## Verification
Random operands almost never make every bit position propagate at once: the chance is 2^-16. As a result, the long carry path through all four groups and the second-level unit would go untested. The stimulus builds such cases on purpose. It picks a random `opA` and sets `opB` to its complement, then drives both carry-in values. It also drives all-ones plus one, and operands that end exactly on each group boundary. These cases exercise the group carries and the word propagate output on top of the random vectors.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Bits handled by one lookahead unit (fan-in limit of a single level).
  parameter int unsigned GROUP_BITS = 4;

  // Generate/propagate pair handed from one lookahead level to the next.
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;

endpackage

// File: rtl/cla_bit_cells.sv
// Per-bit generate and propagate terms.
module cla_bit_cells #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] bitGen,
  output logic [WIDTH-1:0] bitProp
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign bitGen[i]  = opA[i] & opB[i];
    assign bitProp[i] = opA[i] ^ opB[i];
  end

endmodule

// File: rtl/cla_lookahead_unit.sv
// One lookahead level: every carry comes straight from gen/prop and carry-in,
// plus a condensed generate/propagate pair for the next level up.
module cla_lookahead_unit #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] gen,
  input  logic [LANES-1:0] prop,
  input  logic             cin,
  output logic [LANES-1:0] laneCarry,
  output logic             grpGen,
  output logic             grpProp
);

  logic [LANES:0] carryAll;
  logic           chainTerm;
  logic           orTerm;
  logic           genChain;
  logic           genOr;

  // Expanded carries: carry into lane k+1 is an OR of product terms.
  always_comb begin
    carryAll    = '0;
    carryAll[0] = cin;
    chainTerm   = 1'b0;
    orTerm      = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      orTerm = 1'b0;
      for (int j = 0; j <= k; j++) begin
        chainTerm = gen[j];
        for (int m = j + 1; m <= k; m++) begin
          chainTerm = chainTerm & prop[m];
        end
        orTerm = orTerm | chainTerm;
      end
      chainTerm = cin;
      for (int m = 0; m <= k; m++) begin
        chainTerm = chainTerm & prop[m];
      end
      carryAll[k+1] = orTerm | chainTerm;
    end
  end

  // Group generate: the product terms of the top carry without the carry-in.
  always_comb begin
    genOr    = 1'b0;
    genChain = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      genChain = gen[j];
      for (int m = j + 1; m < LANES; m++) begin
        genChain = genChain & prop[m];
      end
      genOr = genOr | genChain;
    end
  end

  assign laneCarry = carryAll[LANES-1:0];
  assign grpGen    = genOr;
  assign grpProp   = &prop;

  // Expanded carries must agree with the one-step recurrence (R7).
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      a_r7_carry_step: assert (carryAll[k+1] == (gen[k] | (prop[k] & carryAll[k])))
        else $error("a_r7_carry_step lane %0d", k);
    end
  end

  // Condensed pair must reproduce the group's top carry (R5).
  always_comb begin
    a_r5_group_pair: assert ((grpGen | (grpProp & cin)) == carryAll[LANES])
      else $error("a_r5_group_pair mismatch");
  end

endmodule

// File: rtl/cla_sum_cells.sv
// Sum bits from propagate and the carry into each position.
module cla_sum_cells #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] bitProp,
  input  logic [WIDTH-1:0] bitCarry,
  output logic [WIDTH-1:0] sumBits
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sumBits[i] = bitProp[i] ^ bitCarry[i];
  end

endmodule

// File: rtl/cla_adder16.sv
// Thin top: bit cells, first-level group units, second-level unit, sum cells.
module cla_adder16 #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             wordGen,
  output logic             wordProp
);

  import cla_pkg::*;

  localparam int unsigned NUM_GROUPS = WIDTH / GROUP_BITS;

  logic [WIDTH-1:0]      bitGen;
  logic [WIDTH-1:0]      bitProp;
  logic [WIDTH-1:0]      bitCarry;
  logic [NUM_GROUPS-1:0] groupCin;
  logic [NUM_GROUPS-1:0] groupGenV;
  logic [NUM_GROUPS-1:0] groupPropV;
  gpPair_t [NUM_GROUPS-1:0] groupGp;

  cla_bit_cells #(.WIDTH(WIDTH)) u_bits (
    .opA     (opA),
    .opB     (opB),
    .bitGen  (bitGen),
    .bitProp (bitProp)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    cla_lookahead_unit #(.LANES(GROUP_BITS)) u_grp (
      .gen       (bitGen[g*GROUP_BITS +: GROUP_BITS]),
      .prop      (bitProp[g*GROUP_BITS +: GROUP_BITS]),
      .cin       (groupCin[g]),
      .laneCarry (bitCarry[g*GROUP_BITS +: GROUP_BITS]),
      .grpGen    (groupGp[g].gen),
      .grpProp   (groupGp[g].prop)
    );
    assign groupGenV[g]  = groupGp[g].gen;
    assign groupPropV[g] = groupGp[g].prop;
  end

  // Second level: same unit, fed with the group pairs.
  cla_lookahead_unit #(.LANES(NUM_GROUPS)) u_top (
    .gen       (groupGenV),
    .prop      (groupPropV),
    .cin       (carryIn),
    .laneCarry (groupCin),
    .grpGen    (wordGen),
    .grpProp   (wordProp)
  );

  cla_sum_cells #(.WIDTH(WIDTH)) u_sum (
    .bitProp  (bitProp),
    .bitCarry (bitCarry),
    .sumBits  (sumOut)
  );

  assign carryOut = wordGen | (wordProp & carryIn);

  // Whole-word result against plain addition (R1, R2).
  always_comb begin
    a_r1_r2_sum: assert ({carryOut, sumOut} ==
                         ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("a_r1_r2_sum mismatch");
  end

  // Word generate must not depend on the carry-in (R3).
  always_comb begin
    a_r3_word_gen: assert (wordGen == (({1'b0, opA} + {1'b0, opB}) >> WIDTH))
      else $error("a_r3_word_gen mismatch");
  end

  // All positions propagating forces the sum to mirror the carry-in (R4).
  always_comb begin
    a_r4_word_prop: assert (!wordProp || (sumOut == {WIDTH{~carryIn}}))
      else $error("a_r4_word_prop mismatch");
  end

endmodule

// File: tb/cla_adder16_bench.sv
module cla_adder16_bench;

  localparam int unsigned WIDTH = 16;
  localparam int unsigned WATCHDOG_CYCLES = 100000;

  typedef struct {
    logic [WIDTH-1:0] expSum;
    logic             expCout;
    logic             expGen;
    logic             expProp;
    string            tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic carryIn = 1'b0;
  logic [WIDTH-1:0] sumOut;
  logic carryOut, wordGen, wordProp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t expQ[$];

  always #4 clk = ~clk;

  cla_adder16 #(.WIDTH(WIDTH)) u_cla_adder16 (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut),
    .wordGen(wordGen), .wordProp(wordProp)
  );

  // Driver: apply at negedge, push expected values computed from requirements.
  task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic c, input string tag);
    item_t it;
    logic [WIDTH:0] full;
    logic [WIDTH:0] noCin;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    full  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
    noCin = {1'b0, a} + {1'b0, b};
    it.expSum  = full[WIDTH-1:0];
    it.expCout = full[WIDTH];
    it.expGen  = noCin[WIDTH];
    it.expProp = ((a ^ b) == {WIDTH{1'b1}});
    it.tag     = tag;
    expQ.push_back(it);
  endtask

  task automatic chk(input bit ok, input string what, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Monitor: inputs changed at negedge, outputs settled by posedge (R9).
  always @(posedge clk) begin
    if (rstN && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      chk(sumOut == it.expSum, {it.tag, " R1 sum"}, sumOut, it.expSum);
      chk(carryOut == it.expCout, {it.tag, " R2 cout"},
          {{(WIDTH-1){1'b0}}, carryOut}, {{(WIDTH-1){1'b0}}, it.expCout});
      chk(wordGen == it.expGen, {it.tag, " R3 wordGen"},
          {{(WIDTH-1){1'b0}}, wordGen}, {{(WIDTH-1){1'b0}}, it.expGen});
      chk(wordProp == it.expProp, {it.tag, " R4 wordProp"},
          {{(WIDTH-1){1'b0}}, wordProp}, {{(WIDTH-1){1'b0}}, it.expProp});
      chk(carryOut == (wordGen | (wordProp & carryIn)), {it.tag, " R5 cout relation"},
          {{(WIDTH-1){1'b0}}, carryOut},
          {{(WIDTH-1){1'b0}}, wordGen | (wordProp & carryIn)});
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] r;
    repeat (2) @(posedge clk);
    // Reset/idle state: zero inputs (R8).
    @(negedge clk);
    rstN = 1'b1;
    chk(sumOut == '0 && !carryOut && !wordGen && !wordProp, "R8 zero state",
        {sumOut[WIDTH-4:0], carryOut, wordGen, wordProp}, '0);
    drive('0, '0, 1'b0, "R8 zeros");
    drive('0, '0, 1'b1, "R1 zeros+cin");
    // Full-length carry chain (R6).
    drive(16'hFFFF, 16'h0000, 1'b1, "R6 ones+cin");
    drive(16'hFFFF, 16'h0001, 1'b0, "R6 ones+1");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R3 max");
    // Group boundaries (R7).
    drive(16'h000F, 16'h0001, 1'b0, "R7 g0->g1");
    drive(16'h00FF, 16'h0001, 1'b0, "R7 g1->g2");
    drive(16'h0FFF, 16'h0001, 1'b0, "R7 g2->g3");
    drive(16'h0FFF, 16'h0000, 1'b1, "R7 cin chain to g3");
    drive(16'h8000, 16'h8000, 1'b0, "R3 top gen");
    // Complementary operands: every position propagates (R4).
    for (int i = 0; i < 40; i++) begin
      r = WIDTH'($urandom);
      drive(r, ~r, 1'b0, "R4 complement c0");
      drive(r, ~r, 1'b1, "R4 complement c1");
    end
    // Random vectors (R1, R2, R9: a new vector every cycle).
    for (int i = 0; i < 400; i++) begin
      drive(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R9 random");
    end
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule